// File: doc/BRIEF.md
# Resonant Current Zero-Crossing Detector

The detector watches signed samples of a resonant tank current, one per clock. It keeps a current-direction flag and emits a single-clock reset pulse whenever it accepts a polarity change. That pulse restarts an external sawtooth counter and marks the half-period boundary for the gate sequencer. After each accepted event, a programmable blanking window stops harmonics and measurement noise from registering as extra crossings.

Measurement, dead-time and gate-rise delays can be compensated. Once enough half periods have passed for the sawtooth amplitude to be known, the flag flips early, as soon as the supplied sawtooth value reaches a compensation threshold. When that threshold is not yet meaningful, or when the sawtooth falls short of it before the current really reverses, the flag follows the true crossing. While the converter is held off, the flag is pinned high. After enable and a fixed delay, the flag is driven low to begin the start-up sequence.

Top module: `rzc_detector`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `dir_o` is 1 and `zc_pulse_o` is 0.
- R2: While `run_i` is 0, `dir_o` is 1 and `zc_pulse_o` stays 0, whatever the samples, sawtooth or threshold.
- R3: When `run_i` goes high and stays high, `dir_o` remains 1 through the first START_DLY rising edges and becomes 0 after edge START_DLY+1. The first of these edges is the one that samples `run_i` high. The forced fall does not produce a pulse.
- R4: A sample counts as positive when its MSB is 0, so zero counts as positive, and as negative when its MSB is 1. A crossing is accepted when the sign differs from the previous sample, the new sign differs from `dir_o`, and no blanking is active. After the edge that samples it, `dir_o` equals the new sign (1 = positive) and `zc_pulse_o` is 1.
- R5: `zc_pulse_o` is high for exactly one clock per accepted event, and every pulse coincides with a change of `dir_o`.
- R6: An accepted event at edge k loads `lock_len_i`. Sign changes sampled at edges k+1 to k+`lock_len_i` are ignored. Detection resumes at edge k+`lock_len_i`+1. A value of 0 gives no blanking.
- R7: A sign change to the polarity that `dir_o` already shows produces neither a pulse nor a flag change.
- R8: An early toggle happens when all of these hold: `comp_en_i` is 1, compensation is armed, blanking is clear, the current sample's sign equals `dir_o`, and `saw_i >= comp_thr_i` (unsigned). On that edge `dir_o` inverts, a pulse is issued and blanking is loaded.
- R9: After an early toggle, the real sign change that follows inside the blanking window leaves `dir_o` and `zc_pulse_o` unchanged.
- R10: Compensation is armed only after ARM_N (default 2) true crossings have been accepted since the last entry into running. Leaving run (`run_i` low) disarms it.
- R11: If the sawtooth is below the threshold when the sign changes, the true crossing is accepted as in R4.
- R12: With `comp_en_i` at 0, no early toggle occurs even when armed and `saw_i >= comp_thr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Converter enable; low holds the blocking condition |
| sample_i | input | SAMPLE_W | Signed two's-complement current sample |
| saw_i | input | SAW_W | Present sawtooth value |
| comp_thr_i | input | SAW_W | Normalized compensation threshold |
| comp_en_i | input | 1 | Allows early switching |
| lock_len_i | input | LOCK_W | Blanking length in clocks |
| dir_o | output | 1 | Current-direction flag (1 = positive) |
| zc_pulse_o | output | 1 | One-clock pulse per accepted event |

## Verification
Some properties hold on every cycle, and the assertions check them there. While disabled, the flag is held high with no pulses. Every pulse coincides with a flag flip. A pulse followed by non-zero blanking cannot pulse again on the next cycle. Without compensation, a pulse leaves the flag equal to the sign of the sample that caused it. The blanking counter is only loaded when idle, and the forced start-up fall always enters running. The directed scenarios cover what needs a history of events: the exact start-up delay, expiry of the blanking window, arming after two true crossings, suppression of the real crossing after an early toggle, and fallback when the sawtooth falls short.

// File: rtl/rzc_pkg.sv
package rzc_pkg;
   typedef enum logic [1:0] {
      RZC_BLOCK = 2'd0,
      RZC_DELAY = 2'd1,
      RZC_RUN   = 2'd2
   } rzc_state_e;
endpackage

// File: rtl/rzc_sign_cmp.sv
module rzc_sign_cmp #(
   parameter int SAMPLE_W = 12
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic signed [SAMPLE_W-1:0] sample_i,
   output logic                       pos_now_o,
   output logic                       changed_o
);
   logic pos_prev_q;

   if (SAMPLE_W < 2) begin : g_bad_width
      $error("rzc_sign_cmp: SAMPLE_W must be at least 2");
   end

   assign pos_now_o = ~sample_i[SAMPLE_W-1];
   assign changed_o = pos_now_o != pos_prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pos_prev_q <= 1'b1;
      else         pos_prev_q <= pos_now_o;
   end
endmodule

// File: rtl/rzc_lockout.sv
module rzc_lockout #(
   parameter int LOCK_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clear_i,
   input  logic              load_i,
   input  logic [LOCK_W-1:0] len_i,
   output logic              idle_o
);
   logic [LOCK_W-1:0] cnt_q;

   if (LOCK_W < 1) begin : g_bad_width
      $error("rzc_lockout: LOCK_W must be at least 1");
   end

   assign idle_o = cnt_q == '0;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cnt_q <= '0;
      else if (clear_i)  cnt_q <= '0;
      else if (load_i)   cnt_q <= len_i;
      else if (!idle_o)  cnt_q <= cnt_q - LOCK_W'(1);
   end

   assert_load_when_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |-> idle_o);
endmodule

// File: rtl/rzc_startup.sv
module rzc_startup
   import rzc_pkg::*;
#(
   parameter int START_DLY = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   output logic active_o,
   output logic force_o
);
   localparam int DLY_W = $clog2(START_DLY + 1);

   rzc_state_e       st_q;
   logic [DLY_W-1:0] cnt_q;

   if (START_DLY < 1) begin : g_bad_dly
      $error("rzc_startup: START_DLY must be at least 1");
   end

   assign force_o  = run_i && st_q == RZC_DELAY && cnt_q == DLY_W'(START_DLY - 1);
   assign active_o = run_i && st_q == RZC_RUN;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q  <= RZC_BLOCK;
         cnt_q <= '0;
      end else if (!run_i) begin
         st_q  <= RZC_BLOCK;
         cnt_q <= '0;
      end else begin
         unique case (st_q)
            RZC_BLOCK: begin
               st_q  <= RZC_DELAY;
               cnt_q <= '0;
            end
            RZC_DELAY: begin
               if (force_o) st_q <= RZC_RUN;
               else         cnt_q <= cnt_q + DLY_W'(1);
            end
            default: st_q <= RZC_RUN;
         endcase
      end
   end

   assert_force_enters_run_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      force_o && run_i |=> st_q == RZC_RUN);
endmodule

// File: rtl/rzc_detector.sv
module rzc_detector #(
   parameter int SAMPLE_W  = 12,
   parameter int SAW_W     = 16,
   parameter int LOCK_W    = 8,
   parameter int START_DLY = 4,
   parameter int ARM_N     = 2,
   parameter bit COMP_EN   = 1'b1
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic                       run_i,
   input  logic signed [SAMPLE_W-1:0] sample_i,
   input  logic        [SAW_W-1:0]    saw_i,
   input  logic        [SAW_W-1:0]    comp_thr_i,
   input  logic                       comp_en_i,
   input  logic        [LOCK_W-1:0]   lock_len_i,
   output logic                       dir_o,
   output logic                       zc_pulse_o
);
   localparam int ARM_W = $clog2(ARM_N + 1);

   logic             pos_now, changed;
   logic             active, force_neg;
   logic             lock_idle;
   logic             true_zc, early_zc, accept;
   logic             dir_q, pulse_q;
   logic [ARM_W-1:0] arm_cnt_q;
   logic             armed;

   if (ARM_N < 1) begin : g_bad_arm
      $error("rzc_detector: ARM_N must be at least 1");
   end

   rzc_sign_cmp #(.SAMPLE_W(SAMPLE_W)) i_cmp (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sample_i  (sample_i),
      .pos_now_o (pos_now),
      .changed_o (changed)
   );

   rzc_startup #(.START_DLY(START_DLY)) i_start (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (run_i),
      .active_o (active),
      .force_o  (force_neg)
   );

   rzc_lockout #(.LOCK_W(LOCK_W)) i_lock (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (!active),
      .load_i  (accept),
      .len_i   (lock_len_i),
      .idle_o  (lock_idle)
   );

   assign armed   = arm_cnt_q == ARM_W'(ARM_N);
   assign true_zc = active && lock_idle && changed && (pos_now != dir_q);

   if (COMP_EN) begin : g_comp
      assign early_zc = active && lock_idle && comp_en_i && armed &&
                        (pos_now == dir_q) && (saw_i >= comp_thr_i);
   end else begin : g_no_comp
      assign early_zc = 1'b0;
   end

   assign accept = true_zc || early_zc;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                arm_cnt_q <= '0;
      else if (!active)           arm_cnt_q <= '0;
      else if (true_zc && !armed) arm_cnt_q <= arm_cnt_q + ARM_W'(1);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         dir_q   <= 1'b1;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= accept;
         if (force_neg)     dir_q <= 1'b0;
         else if (!active)  dir_q <= 1'b1;
         else if (true_zc)  dir_q <= pos_now;
         else if (early_zc) dir_q <= ~dir_q;
      end
   end

   assign dir_o      = dir_q;
   assign zc_pulse_o = pulse_q;

   assert_blocked_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(!run_i) |-> dir_o && !zc_pulse_o);

   assert_pulse_flips_dir_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      zc_pulse_o |-> dir_o != $past(dir_o));

   assert_blank_after_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      zc_pulse_o && ($past(lock_len_i) != '0) |=> !zc_pulse_o);

   assert_true_sign_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      zc_pulse_o && !$past(comp_en_i) |-> dir_o == !$past(sample_i[SAMPLE_W-1]));
endmodule

// File: tb/test_rzc_detector.sv
`timescale 1ns/1ps
module test_rzc_detector;
   localparam logic signed [11:0] NEG = -12'sd40;
   localparam logic signed [11:0] POS = 12'sd40;
   localparam logic signed [11:0] ZER = 12'sd0;
   localparam logic [15:0] HI  = 16'd200;
   localparam logic [15:0] LO  = 16'd10;
   localparam logic [15:0] MID = 16'd50;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic run = 1'b0;
   logic signed [11:0] sample = '0;
   logic [15:0] saw = '0;
   logic [15:0] thr = 16'd100;
   logic comp_en = 1'b0;
   logic [7:0] lock_len = 8'd3;
   logic dir, pulse;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   rzc_detector i_rzc_detector (
      .clk_i(clk), .rst_ni(rst_n), .run_i(run), .sample_i(sample),
      .saw_i(saw), .comp_thr_i(thr), .comp_en_i(comp_en),
      .lock_len_i(lock_len), .dir_o(dir), .zc_pulse_o(pulse)
   );

   task automatic chk(input string req, input logic exp_dir, input logic exp_pulse);
      checks++;
      if (dir !== exp_dir || pulse !== exp_pulse) begin
         errors++;
         $display("FAIL %s: dir=%b pulse=%b expected dir=%b pulse=%b",
                  req, dir, pulse, exp_dir, exp_pulse);
      end
   endtask

   task automatic step(input logic signed [11:0] s, input logic [15:0] sw);
      sample = s;
      saw    = sw;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset;
      repeat (2) @(negedge clk);
      chk("R1 in reset", 1'b1, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after reset", 1'b1, 1'b0);
   endtask

   task automatic t_block;
      run = 1'b0;
      step(NEG, HI); chk("R2 blocked neg", 1'b1, 1'b0);
      step(POS, HI); chk("R2 blocked pos", 1'b1, 1'b0);
      step(NEG, LO); chk("R2 blocked neg again", 1'b1, 1'b0);
   endtask

   task automatic t_startup;
      run = 1'b1;
      for (int i = 0; i < 4; i++) begin
         step(ZER, LO); chk("R3 delay holds high", 1'b1, 1'b0);
      end
      step(ZER, LO); chk("R3 forced low, no pulse", 1'b0, 1'b0);
   endtask

   task automatic t_true;
      step(NEG, LO); chk("R7 change to matching sign ignored", 1'b0, 1'b0);
      step(POS, LO); chk("R4 true crossing to positive", 1'b1, 1'b1);
      step(POS, LO); chk("R5 pulse one clock", 1'b1, 1'b0);
      step(NEG, LO); chk("R6 change inside blanking ignored", 1'b1, 1'b0);
      step(POS, LO); chk("R6 blanking still active", 1'b1, 1'b0);
      step(NEG, LO); chk("R6 detection after blanking", 1'b0, 1'b1);
   endtask

   task automatic t_nocomp;
      comp_en = 1'b0;
      for (int i = 0; i < 4; i++) begin
         step(NEG, HI); chk("R12 no early toggle when disabled", 1'b0, 1'b0);
      end
   endtask

   task automatic t_early;
      comp_en = 1'b1;
      step(NEG, HI); chk("R8 early toggle at threshold", 1'b1, 1'b1);
      step(POS, LO); chk("R9 real crossing after early ignored", 1'b1, 1'b0);
      step(POS, LO); chk("R9 flag holds", 1'b1, 1'b0);
      step(POS, LO); chk("R9 flag holds", 1'b1, 1'b0);
      step(POS, LO); chk("R9 no extra event", 1'b1, 1'b0);
   endtask

   task automatic t_fallback;
      step(NEG, MID); chk("R11 true crossing when saw short", 1'b0, 1'b1);
      step(NEG, MID); chk("R11 single pulse", 1'b0, 1'b0);
   endtask

   task automatic t_rearm;
      run = 1'b0;
      step(NEG, LO); chk("R2 disable forces high", 1'b1, 1'b0);
      run = 1'b1;
      for (int i = 0; i < 4; i++) step(NEG, LO);
      step(NEG, LO); chk("R3 restart forced low", 1'b0, 1'b0);
      step(NEG, HI); chk("R10 unarmed after restart", 1'b0, 1'b0);
      step(POS, LO); chk("R10 first true crossing", 1'b1, 1'b1);
      for (int i = 0; i < 3; i++) step(POS, HI);
      step(POS, HI); chk("R10 one crossing not enough", 1'b1, 1'b0);
      step(NEG, LO); chk("R10 second true crossing", 1'b0, 1'b1);
      for (int i = 0; i < 3; i++) step(NEG, LO);
      step(NEG, HI); chk("R10 armed early toggle", 1'b1, 1'b1);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_block();
      t_startup();
      t_true();
      t_nocomp();
      t_early();
      t_fallback();
      t_rearm();
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end
endmodule